// File: doc/BRIEF.md
# Load-Multiple Transfer Sequencer

This block carries out the memory side of a load-multiple instruction for a small 32-bit processor core. On a start strobe it captures the decoded instruction word and the current value of the base register. It counts the selected registers, works out the first address for the addressing mode, and then issues one word read per selected register. Registers are taken in ascending number order. Each returned word leaves the block at once as a register-file write, or as a branch when the register is the program counter.

When the list is exhausted, the block gives a one-cycle completion pulse. The pulse carries the base-register writeback and an unpredictable-case flag. Condition evaluation, the register file, mode banking and instruction fetch are handled elsewhere. The block never touches the condition flags; it only asks for a status restore when a privileged branch-return form is decoded.

Top module: `ldm_seq`

## Requirements
- R1: After reset, busy, done, mem_req, rf_we, pc_load and wb_en are all low.
- R2: Instruction bits 24 (pre) and 23 (up) select the mode. With pre=0, up=1 the first read is at the base, and each further read is 4 higher, in ascending register order.
- R3: With pre=1, up=1 the first read is at base+4.
- R4: With pre=0, up=0 the first read is at base-4*N+4, where N is the number of set bits in the list (instruction bits 15:0).
- R5: With pre=1, up=0 the first read is at base-4*N.
- R6: When bit 21 (writeback) is set, the done pulse carries wb_en=1, wb_reg equal to bits 19:16, and wb_data equal to base+4*N (up=1) or base-4*N (up=0). When bit 21 is clear, wb_en stays 0.
- R7: When writeback is requested and the list includes the base register, wb_en stays 0 and unpred is 1 during the done pulse.
- R8: Register 15 is read last, from the highest address. Its word appears on pc_target with a pc_load strobe and never as an rf_we write. Every other register is written through rf_we/rf_idx.
- R9: psr_restore is asserted with pc_load exactly when bit 22 is set. Without register 15 in the list, psr_restore is never raised.
- R10: An empty list makes no memory read and ends with a done pulse carrying unpred=1 and wb_en=0.
- R11: mem_req and mem_addr hold until mem_valid is seen. The returned word appears on rf_wdata/pc_target in the same cycle as mem_valid.
- R12: busy goes high the cycle after an accepted start and falls after the one-cycle done pulse. A start seen while busy is ignored.
- R13: Every issued mem_addr has its two low bits cleared, even when the base is not word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| instr | input | 32 | Decoded load-multiple instruction word |
| base_val | input | 32 | Current base register value |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Word-aligned read address |
| mem_valid | input | 1 | Read data valid, completes the request |
| mem_rdata | input | 32 | Read data |
| rf_we | output | 1 | Register-file write enable |
| rf_idx | output | 4 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |
| pc_load | output | 1 | Branch strobe for a loaded program counter |
| pc_target | output | 32 | Branch target |
| psr_restore | output | 1 | Status-restore request alongside the branch |
| wb_en | output | 1 | Base writeback enable (with done) |
| wb_reg | output | 4 | Base register index |
| wb_data | output | 32 | Base writeback value |
| unpred | output | 1 | Unpredictable form flag (with done) |

## Verification
The hardest situation to reach from the ports is a start strobe that arrives in the middle of a transfer while the memory side is stalling. A responder that adds wait cycles makes the window long enough, and the driver raises start with a different word and base during it. The expected read sequence and writeback then show that nothing changed. The other delicate cases, program counter ordering with the status request and base-in-list writeback, are produced by choosing lists that pair register 15 or the base register with the other modes. Unaligned bases and multi-cycle latencies are mixed in to stress address holding.

// File: rtl/ldm_seq_pkg.sv
package ldm_seq_pkg;

    localparam int XLEN   = 32;
    localparam int NREG   = 16;
    localparam int RIDX   = $clog2(NREG);
    localparam int CNTW   = $clog2(NREG + 1);
    localparam int PC_IDX = NREG - 1;

    typedef struct packed {
        logic [3:0]      cond;
        logic [2:0]      cls;
        logic            pre;
        logic            up;
        logic            usr;
        logic            wbk;
        logic            ld;
        logic [RIDX-1:0] base_reg;
        logic [NREG-1:0] regs;
    } ldm_word_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_CALC,
        S_XFER,
        S_FIN
    } ldm_state_t;

    // encoded as {pre, up}
    typedef enum logic [1:0] {
        M_DA = 2'b00,
        M_IA = 2'b01,
        M_DB = 2'b10,
        M_IB = 2'b11
    } ldm_mode_t;

    function automatic logic [CNTW-1:0] ldm_popcnt(input logic [NREG-1:0] v);
        logic [CNTW-1:0] n;
        n = '0;
        for (int i = 0; i < NREG; i++)
            n = n + CNTW'(v[i]);
        return n;
    endfunction

    function automatic logic [XLEN-1:0] word_align(input logic [XLEN-1:0] a);
        return {a[XLEN-1:2], 2'b00};
    endfunction

endpackage

// File: rtl/ldm_addr_gen.sv
module ldm_addr_gen
    import ldm_seq_pkg::*;
(
    input  ldm_mode_t       mode,
    input  logic [XLEN-1:0] base,
    input  logic [CNTW-1:0] cnt,
    output logic [XLEN-1:0] first_addr,
    output logic [XLEN-1:0] final_base
);
    logic [XLEN-1:0] span;

    assign span = XLEN'(cnt) << 2;

    always_comb begin
        case (mode)
            M_IA:    first_addr = base;
            M_IB:    first_addr = base + XLEN'(4);
            M_DA:    first_addr = base - span + XLEN'(4);
            default: first_addr = base - span;
        endcase
        final_base = mode[0] ? (base + span) : (base - span);
    end
endmodule

// File: rtl/ldm_lowbit.sv
module ldm_lowbit #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  mask,
    output logic [IW-1:0] idx,
    output logic          any
);
    // seen[i]: some bit below i is set
    logic [N:0] seen;
    logic [N-1:0] hit;

    assign seen[0] = 1'b0;
    generate
        for (genvar g = 0; g < N; g++) begin : g_chain
            assign hit[g]    = mask[g] & ~seen[g];
            assign seen[g+1] = seen[g] | mask[g];
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++)
            if (hit[i]) idx = IW'(i);
    end

    assign any = seen[N];
endmodule

// File: rtl/ldm_seq.sv
module ldm_seq
    import ldm_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [XLEN-1:0] instr,
    input  logic [XLEN-1:0] base_val,
    output logic            busy,
    output logic            done,
    output logic            mem_req,
    output logic [XLEN-1:0] mem_addr,
    input  logic            mem_valid,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            rf_we,
    output logic [RIDX-1:0] rf_idx,
    output logic [XLEN-1:0] rf_wdata,
    output logic            pc_load,
    output logic [XLEN-1:0] pc_target,
    output logic            psr_restore,
    output logic            wb_en,
    output logic [RIDX-1:0] wb_reg,
    output logic [XLEN-1:0] wb_data,
    output logic            unpred
);
    ldm_state_t      st;
    ldm_word_t       iw;
    logic [XLEN-1:0] base_q;
    logic [NREG-1:0] mask_q;
    logic [XLEN-1:0] addr_q;
    logic [XLEN-1:0] wbv_q;
    logic            wben_q;
    logic            unp_q;

    logic [CNTW-1:0] cnt;
    logic [XLEN-1:0] first_addr;
    logic [XLEN-1:0] final_base;
    logic [RIDX-1:0] cur_idx;
    logic            cur_any;
    logic            cur_is_pc;
    logic            accept;
    logic [NREG-1:0] mask_nx;
    logic            base_listed;
    logic            unused_bits;

    assign unused_bits = ^{iw.cond, iw.cls, iw.ld, cur_any};

    assign cnt         = ldm_popcnt(iw.regs);
    assign base_listed = iw.regs[iw.base_reg];

    ldm_addr_gen u_addr (
        .mode       (ldm_mode_t'({iw.pre, iw.up})),
        .base       (base_q),
        .cnt        (cnt),
        .first_addr (first_addr),
        .final_base (final_base)
    );

    ldm_lowbit #(.N(NREG), .IW(RIDX)) u_pick (
        .mask (mask_q),
        .idx  (cur_idx),
        .any  (cur_any)
    );

    assign cur_is_pc = (cur_idx == RIDX'(PC_IDX));
    assign accept    = (st == S_XFER) && mem_valid;
    assign mask_nx   = mask_q & ~(NREG'(1) << cur_idx);

    assign busy        = (st != S_IDLE);
    assign done        = (st == S_FIN);
    assign mem_req     = (st == S_XFER);
    assign mem_addr    = word_align(addr_q);
    assign rf_we       = accept && !cur_is_pc;
    assign rf_idx      = cur_idx;
    assign rf_wdata    = mem_rdata;
    assign pc_load     = accept && cur_is_pc;
    assign pc_target   = mem_rdata;
    assign psr_restore = pc_load && iw.usr;
    assign wb_en       = done && wben_q;
    assign wb_reg      = iw.base_reg;
    assign wb_data     = wbv_q;
    assign unpred      = done && unp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            iw     <= '0;
            base_q <= '0;
            mask_q <= '0;
            addr_q <= '0;
            wbv_q  <= '0;
            wben_q <= 1'b0;
            unp_q  <= 1'b0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (start) begin
                        iw     <= ldm_word_t'(instr);
                        base_q <= base_val;
                        st     <= S_CALC;
                    end
                end
                S_CALC: begin
                    mask_q <= iw.regs;
                    addr_q <= first_addr;
                    wbv_q  <= final_base;
                    wben_q <= iw.wbk && !base_listed && (cnt != '0);
                    unp_q  <= (cnt == '0) || (iw.wbk && base_listed);
                    st     <= (cnt == '0) ? S_FIN : S_XFER;
                end
                S_XFER: begin
                    if (mem_valid) begin
                        mask_q <= mask_nx;
                        addr_q <= addr_q + XLEN'(4);
                        if (mask_nx == '0) st <= S_FIN;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ldm_seq_chk.sv
module ldm_seq_chk
    import ldm_seq_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic            mem_req,
    input logic [XLEN-1:0] mem_addr,
    input logic            mem_valid,
    input logic            rf_we,
    input logic [RIDX-1:0] rf_idx,
    input logic            pc_load,
    input logic            psr_restore,
    input logic            wb_en,
    input logic            unpred
);
    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_valid |=> mem_req && $stable(mem_addr));

    // R11
    data_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (rf_we || pc_load) |-> (mem_req && mem_valid));

    // R13
    addr_align_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    // R12
    start_takes_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);

    // R8
    pc_not_rf_chk: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (rf_idx != RIDX'(PC_IDX)));

    // R8
    one_sink_chk: assert property (@(posedge clk) disable iff (rst)
        !(rf_we && pc_load));

    // R9
    psr_with_branch_chk: assert property (@(posedge clk) disable iff (rst)
        psr_restore |-> pc_load);

    // R6
    wb_at_done_chk: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> done);

    // R7
    wb_excl_unpred_chk: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> !unpred);
endmodule

bind ldm_seq ldm_seq_chk u_chk (.*);

// File: tb/ldm_seq_test.sv
module ldm_seq_test;
    import ldm_seq_pkg::*;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [31:0] addr;
        logic [3:0]  idx;
        bit          is_pc;
        bit          psr;
    } exp_rd_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] base_val = '0;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        busy, done, mem_req, rf_we, pc_load, psr_restore, wb_en, unpred;
    logic [31:0] mem_addr, rf_wdata, pc_target, wb_data;
    logic [3:0]  rf_idx, wb_reg;

    int      n_chk = 0;
    int      n_fail = 0;
    int      lat = 0;
    string   cur_tag = "R2";
    bit      finished = 0;
    exp_rd_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ldm_seq uut (
        .clk(clk), .rst(rst), .start(start), .instr(instr), .base_val(base_val),
        .busy(busy), .done(done), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata), .rf_we(rf_we),
        .rf_idx(rf_idx), .rf_wdata(rf_wdata), .pc_load(pc_load),
        .pc_target(pc_target), .psr_restore(psr_restore), .wb_en(wb_en),
        .wb_reg(wb_reg), .wb_data(wb_data), .unpred(unpred)
    );

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    // memory responder and scoreboard monitor
    initial begin
        int waited = 0;
        forever begin
            @(negedge clk);
            mem_valid = 1'b0;
            if (mem_req) begin
                if (waited < lat) begin
                    waited++;
                end else begin
                    exp_rd_t e;
                    waited = 0;
                    mem_valid = 1'b1;
                    mem_rdata = pat(mem_addr);
                    #1;
                    if (exp_q.size() == 0) begin
                        check("R10 unexpected read", 32'd1, 32'd0);
                    end else begin
                        e = exp_q.pop_front();
                        check({cur_tag, " address"}, mem_addr, e.addr);
                        check("R8 rf_we", {31'd0, rf_we}, {31'd0, !e.is_pc});
                        check("R8 pc_load", {31'd0, pc_load}, {31'd0, e.is_pc});
                        check("R9 psr_restore", {31'd0, psr_restore}, {31'd0, e.psr});
                        if (e.is_pc) begin
                            check("R8 pc_target", pc_target, pat(e.addr));
                        end else begin
                            check("R2 rf_idx order", {28'd0, rf_idx}, {28'd0, e.idx});
                            check("R11 rf_wdata", rf_wdata, pat(e.addr));
                        end
                    end
                end
            end else begin
                waited = 0;
            end
        end
    end

    task automatic run_op(input string tag, input bit p, input bit u, input bit s,
                          input bit w, input logic [3:0] rn, input logic [15:0] list,
                          input logic [31:0] base, input int latency, input bit glitch);
        int          c = 0;
        logic [31:0] a;
        logic [31:0] wbv;
        bit          exp_wb;
        bit          exp_un;
        bit          got_done = 0;
        for (int i = 0; i < 16; i++) if (list[i]) c++;
        if (!p && u)      a = base;
        else if (p && u)  a = base + 32'd4;
        else if (!p && !u) a = base - 32'(4*c) + 32'd4;
        else              a = base - 32'(4*c);
        a = {a[31:2], 2'b00};
        for (int i = 0; i < 16; i++) begin
            if (list[i]) begin
                exp_rd_t e;
                e.addr  = a;
                e.idx   = 4'(i);
                e.is_pc = (i == 15);
                e.psr   = (i == 15) && s;
                exp_q.push_back(e);
                a = a + 32'd4;
            end
        end
        wbv    = u ? base + 32'(4*c) : base - 32'(4*c);
        exp_un = (c == 0) || (w && list[rn]);
        exp_wb = w && !list[rn] && (c != 0);
        cur_tag = tag;
        lat     = latency;

        @(negedge clk);
        start    = 1'b1;
        instr    = {4'hE, 3'b100, p, u, s, w, 1'b1, rn, list};
        base_val = base;
        @(negedge clk);
        start = 1'b0;
        check("R12 busy after start", {31'd0, busy}, 32'd1);
        for (int k = 0; k < 300 && !got_done; k++) begin
            if (done) begin
                got_done = 1;
            end else begin
                if (glitch && k == 2) begin
                    start    = 1'b1;
                    instr    = {4'hE, 3'b100, 4'b0110, 1'b1, 4'd9, 16'h0F0F};
                    base_val = 32'h0000_9000;
                end else begin
                    start = 1'b0;
                end
                @(negedge clk);
            end
        end
        start = 1'b0;
        check("R12 done seen", {31'd0, got_done}, 32'd1);
        check("R6 wb_en", {31'd0, wb_en}, {31'd0, exp_wb});
        if (exp_wb) begin
            check("R6 wb_data", wb_data, wbv);
            check("R6 wb_reg", {28'd0, wb_reg}, {28'd0, rn});
        end
        check("R7 unpred", {31'd0, unpred}, {31'd0, exp_un});
        check("R10 reads left", 32'(exp_q.size()), 32'd0);
        exp_q.delete();
        @(negedge clk);
        check("R12 idle after done", {31'd0, busy}, 32'd0);
        check("R12 done one cycle", {31'd0, done}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", {31'd0, busy}, 32'd0);
        check("R1 done", {31'd0, done}, 32'd0);
        check("R1 mem_req", {31'd0, mem_req}, 32'd0);
        check("R1 rf_we", {31'd0, rf_we}, 32'd0);
        check("R1 pc_load", {31'd0, pc_load}, 32'd0);
        check("R1 wb_en", {31'd0, wb_en}, 32'd0);

        run_op("R2", 0, 1, 0, 1, 4'd1,  16'h00E4, 32'h0000_1000, 0, 0);
        run_op("R3", 1, 1, 0, 1, 4'd3,  16'h0301, 32'h0000_2000, 2, 0);
        run_op("R4", 0, 0, 0, 1, 4'd4,  16'h1030, 32'h0000_3000, 1, 0);
        // R5 with R12 start-while-busy glitch
        run_op("R5", 1, 0, 0, 1, 4'd13, 16'h40F0, 32'h0000_4000, 3, 1);
        // R6 no writeback when bit 21 clear
        run_op("R6", 0, 1, 0, 0, 4'd5,  16'h000F, 32'h0000_5000, 0, 0);
        // R7 base register in list with writeback
        run_op("R7", 0, 1, 0, 1, 4'd2,  16'h0006, 32'h0000_6000, 1, 0);
        // R8 program counter last
        run_op("R8", 0, 1, 0, 1, 4'd0,  16'h800A, 32'h0000_7000, 0, 0);
        // R9 status restore with the branch, and not without register 15
        run_op("R9", 1, 0, 1, 1, 4'd12, 16'h8101, 32'h0000_8000, 1, 0);
        run_op("R9", 0, 1, 1, 0, 4'd12, 16'h0003, 32'h0000_8800, 0, 0);
        // R10 empty list
        run_op("R10", 0, 1, 0, 1, 4'd6, 16'h0000, 32'h0000_9000, 0, 0);
        // R13 unaligned base, R11 long stall
        run_op("R13", 0, 1, 0, 1, 4'd7, 16'h0005, 32'h0000_1003, 4, 0);
        // full list, decrement-after
        run_op("R4", 0, 0, 0, 0, 4'd0, 16'hFFFF, 32'h0001_0000, 0, 0);
        summary();
    end
endmodule